// File: doc/BRIEF.md
# RGB Colour Correction Pipeline

This block takes a stream of 12-bit RGB triplets, one per clock when `in_valid` is high, together with a line-valid flag. It applies a separate white-balance gain to each channel, then mixes the three balanced channels through a programmable signed 3x3 matrix. A set of registers holds the coefficients that are in use. Software loads them one at a time through a simple write port. It can also copy the whole matrix into one of four user slots, or load the matrix from a user slot or from one of four fixed presets by index.

A bypass bit skips the matrix so that the white-balanced triplet is output unchanged. The data path has two register stages. The valid and line-valid flags travel through the same number of stages, so they stay aligned with the data.

Top module: `rgb_ccm`

## Requirements
- R1: Output data, `out_valid` and `out_line` appear exactly two clock edges after the inputs are sampled. `out_valid` and `out_line` equal `in_valid` and `in_line` from two cycles earlier.
- R2: Each channel is multiplied by a factor taken from its 6-bit gain code k. The factor is M(k)/1024, where M(0)=1024 and M(k)=(M(k-1)*66990+32768)>>16. The balanced value is (x*M(k)+512)>>10, saturated at 4095.
- R3: With bypass off, each output channel is the sum of three terms: each balanced input channel times its own signed 10-bit two's-complement coefficient. Add 64 to the sum, shift it arithmetically right by 7, and clamp the result to 0..4095.
- R4: With bypass set, the outputs equal the white-balanced triplet and the matrix has no effect.
- R5: Config addresses select what a write changes:
  - 0..8 are the coefficients in row-major order. The row is the output channel R, G, B and the column is the input channel R, G, B.
  - 9, 10 and 11 take the red, green and blue gain codes from data bits [5:0].
  - 12 takes the bypass bit from data bit 0.
  - Writes to 13..15 change nothing.
- R6: `bank_cmd`=1 (store) with index 1..4 copies the active matrix into that user slot. Store with any other index does nothing.
- R7: `bank_cmd`=2 (recall) with index 1..4 loads that user slot into the active matrix. Indices 5..8 load a preset. Indices 0 and 9..15 change nothing. The presets, in units of 1/128, are:
  - 5: rows (146,33,-51), (-24,219,-67), (-58,-83,269)
  - 6: identity (128 on the diagonal, 0 elsewhere)
  - 7: 160 on the diagonal, -16 elsewhere
  - 8: 136 on the diagonal, -4 elsewhere
- R8: A store or recall that is accepted drops any config write in the same cycle. A bank command that is ignored leaves that write in effect.
- R9: While reset is held, all outputs are zero. After reset the active matrix and all user slots are identity, all gain codes are 0 and bypass is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input triplet valid |
| in_line | input | 1 | Input line-valid flag |
| in_r | input | 12 | Red input |
| in_g | input | 12 | Green input |
| in_b | input | 12 | Blue input |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Config register select |
| cfg_data | input | 10 | Config write data |
| bank_cmd | input | 2 | 0 idle, 1 store, 2 recall, 3 idle |
| bank_idx | input | 4 | Slot or preset index |
| out_valid | output | 1 | Output triplet valid |
| out_line | output | 1 | Output line-valid flag |
| out_r | output | 12 | Red output |
| out_g | output | 12 | Green output |
| out_b | output | 12 | Blue output |

## Verification
Some faults sit inside the block and never show up as a wrong flag. A corrupted active coefficient, a store into the wrong slot, or a gain lookup that is off by one entry all show up at the ports only as wrong pixel values. A matrix fault is visible two cycles after the next triplet enters. A slot fault stays hidden until that slot is recalled and a pixel is sent. The stimulus therefore recalls a slot and sends a pixel right after every bank operation. Saturated and negative sums are driven on purpose, because a mistake in clamping or rounding appears only at the extremes of the range.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;
    localparam int PIX_W       = 12;
    localparam int COEF_W      = 10;
    localparam int COEF_FRAC   = 7;
    localparam int WB_W        = 6;
    localparam int WB_FRAC     = 10;
    localparam int WB_MUL_W    = 13;
    localparam int WB_STEP_Q16 = 66990;
    localparam int NCH         = 3;
    localparam int NCOEF       = NCH * NCH;
    localparam int USER_SLOTS  = 4;
    localparam int NPRESET     = 4;
    localparam int IDX_W       = $clog2(USER_SLOTS + NPRESET + 1);
    localparam int SLOT_W      = $clog2(USER_SLOTS);
    localparam int PSEL_W      = $clog2(NPRESET);
    localparam int CFG_AW      = 4;
    localparam int ADDR_WB     = NCOEF;
    localparam int ADDR_BYP    = NCOEF + NCH;
    localparam int UNITY       = 1 << COEF_FRAC;
    localparam int PIX_MAX     = (1 << PIX_W) - 1;
    localparam int WB_PW       = PIX_W + WB_MUL_W + 1;
    localparam int ACC_W       = COEF_W + PIX_W + 3;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [WB_W-1:0]          wb_code_t;
    typedef logic [WB_MUL_W-1:0]      wb_mul_t;
    typedef struct packed { pix_t r; pix_t g; pix_t b; } rgb_t;
    typedef coef_t [NCOEF-1:0]        mat_t;
    typedef enum logic [1:0] {
        BANK_IDLE   = 2'd0,
        BANK_STORE  = 2'd1,
        BANK_RECALL = 2'd2,
        BANK_RSVD   = 2'd3
    } bank_cmd_t;

    // Gain multiplier for a code: geometric steps of about 0.19 dB from unity.
    function automatic wb_mul_t wb_mult(input int code);
        int m;
        m = 1 << WB_FRAC;
        for (int k = 0; k < code; k++) m = (m * WB_STEP_Q16 + 32768) >>> 16;
        return wb_mul_t'(m);
    endfunction

    function automatic pix_t wb_apply(input pix_t x, input wb_mul_t m);
        logic [WB_PW-1:0] p;
        p = (WB_PW'(x) * WB_PW'(m) + WB_PW'(1 << (WB_FRAC - 1))) >> WB_FRAC;
        return (p > WB_PW'(PIX_MAX)) ? '1 : pix_t'(p);
    endfunction

    function automatic pix_t mat_row(input coef_t c0, input coef_t c1, input coef_t c2,
                                     input pix_t x0, input pix_t x1, input pix_t x2);
        logic signed [ACC_W-1:0] acc;
        acc = ACC_W'(c0) * $signed(ACC_W'(x0))
            + ACC_W'(c1) * $signed(ACC_W'(x1))
            + ACC_W'(c2) * $signed(ACC_W'(x2));
        acc = acc + ACC_W'(UNITY / 2);
        acc = acc >>> COEF_FRAC;
        if (acc < 0) return '0;
        if (acc > ACC_W'(PIX_MAX)) return '1;
        return pix_t'(acc);
    endfunction

    function automatic mat_t identity_mat();
        mat_t m;
        for (int i = 0; i < NCOEF; i++)
            m[i] = (i % (NCH + 1) == 0) ? coef_t'(UNITY) : '0;
        return m;
    endfunction

    function automatic mat_t preset_mat(input int p);
        mat_t m;
        int on_diag, off_diag;
        on_diag  = UNITY;
        off_diag = 0;
        if (p == 2) begin on_diag = 160; off_diag = -16; end
        if (p == 3) begin on_diag = 136; off_diag = -4;  end
        for (int i = 0; i < NCOEF; i++)
            m[i] = coef_t'((i % (NCH + 1) == 0) ? on_diag : off_diag);
        if (p == 0) begin
            m[0] = coef_t'(146);  m[1] = coef_t'(33);   m[2] = coef_t'(-51);
            m[3] = coef_t'(-24);  m[4] = coef_t'(219);  m[5] = coef_t'(-67);
            m[6] = coef_t'(-58);  m[7] = coef_t'(-83);  m[8] = coef_t'(269);
        end
        return m;
    endfunction
endpackage

// File: rtl/ccm_coef_bank.sv
`timescale 1ns/1ps
module ccm_coef_bank
    import ccm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [COEF_W-1:0]       cfg_data,
    input  logic [1:0]              bank_cmd,
    input  logic [IDX_W-1:0]        bank_idx,
    output mat_t                    act,
    output wb_code_t [NCH-1:0]      wb_codes,
    output logic                    bypass
);
    bank_cmd_t         cmd;
    logic              idx_user, idx_preset, do_store, do_recall, wr_ok;
    logic [SLOT_W-1:0] slot_sel;
    logic [PSEL_W-1:0] pre_sel;
    mat_t              slots   [USER_SLOTS];
    mat_t              presets [NPRESET];
    mat_t              recall_src;

    assign cmd        = bank_cmd_t'(bank_cmd);
    assign idx_user   = (bank_idx != '0) && (bank_idx <= IDX_W'(USER_SLOTS));
    assign idx_preset = (bank_idx > IDX_W'(USER_SLOTS)) && (bank_idx <= IDX_W'(USER_SLOTS + NPRESET));
    assign slot_sel   = SLOT_W'(bank_idx - IDX_W'(1));
    assign pre_sel    = PSEL_W'(bank_idx - IDX_W'(USER_SLOTS + 1));
    assign do_store   = (cmd == BANK_STORE) && idx_user;
    assign do_recall  = (cmd == BANK_RECALL) && (idx_user || idx_preset);
    assign wr_ok      = cfg_we && !(do_store || do_recall);
    assign recall_src = idx_user ? slots[slot_sel] : presets[pre_sel];

    for (genvar p = 0; p < NPRESET; p++) begin : g_preset
        assign presets[p] = preset_mat(p);
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < USER_SLOTS; s++) begin
            if (rst)
                slots[s] <= identity_mat();
            else if (do_store && slot_sel == SLOT_W'(s))
                slots[s] <= act;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act      <= identity_mat();
            wb_codes <= '0;
            bypass   <= 1'b0;
        end else if (do_recall) begin
            act <= recall_src;
        end else if (wr_ok) begin
            for (int i = 0; i < NCOEF; i++)
                if (cfg_addr == CFG_AW'(i)) act[i] <= coef_t'(cfg_data);
            for (int c = 0; c < NCH; c++)
                if (cfg_addr == CFG_AW'(ADDR_WB + c)) wb_codes[c] <= cfg_data[WB_W-1:0];
            if (cfg_addr == CFG_AW'(ADDR_BYP)) bypass <= cfg_data[0];
        end
    end

    assert_bypass_write_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_AW'(ADDR_BYP) && bank_cmd == 2'd0) |=> bypass == $past(cfg_data[0]));
    assert_store_slot_R6: assert property (@(posedge clk) disable iff (rst)
        (bank_cmd == 2'd1 && bank_idx == IDX_W'(1)) |=> slots[0] == $past(act));
    assert_recall_unity_R7: assert property (@(posedge clk) disable iff (rst)
        (bank_cmd == 2'd2 && bank_idx == IDX_W'(USER_SLOTS + 2)) |=> act == identity_mat());
    assert_bad_index_R7: assert property (@(posedge clk) disable iff (rst)
        (bank_cmd == 2'd2 && (bank_idx == '0 || bank_idx > IDX_W'(USER_SLOTS + NPRESET)) && !cfg_we)
        |=> $stable(act));
    assert_write_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_AW'(ADDR_BYP) && bank_cmd == 2'd2 && bank_idx == IDX_W'(1))
        |=> $stable(bypass));
endmodule

// File: rtl/ccm_wb_stage.sv
`timescale 1ns/1ps
module ccm_wb_stage
    import ccm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_line,
    input  rgb_t               in_pix,
    input  wb_code_t [NCH-1:0] codes,
    output logic               s1_valid,
    output logic               s1_line,
    output rgb_t               s1_pix
);
    localparam int LUT_N = 1 << WB_W;

    wb_mul_t lut  [LUT_N];
    pix_t    pin  [NCH];
    pix_t    pout [NCH];

    for (genvar k = 0; k < LUT_N; k++) begin : g_lut
        assign lut[k] = wb_mult(k);
    end

    assign pin[0] = in_pix.r;
    assign pin[1] = in_pix.g;
    assign pin[2] = in_pix.b;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign pout[c] = wb_apply(pin[c], lut[codes[c]]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_line  <= 1'b0;
            s1_pix   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_line  <= in_line;
            s1_pix   <= '{r: pout[0], g: pout[1], b: pout[2]};
        end
    end

    assert_unity_gain_R2: assert property (@(posedge clk) disable iff (rst)
        (codes[0] == '0 && codes[2] == '0) |=> (s1_pix.r == $past(in_pix.r) && s1_pix.b == $past(in_pix.b)));
endmodule

// File: rtl/ccm_matrix_stage.sv
`timescale 1ns/1ps
module ccm_matrix_stage
    import ccm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic s1_valid,
    input  logic s1_line,
    input  rgb_t s1_pix,
    input  mat_t coefs,
    input  logic bypass,
    output logic out_valid,
    output logic out_line,
    output rgb_t out_pix
);
    pix_t pin  [NCH];
    pix_t mout [NCH];

    assign pin[0] = s1_pix.r;
    assign pin[1] = s1_pix.g;
    assign pin[2] = s1_pix.b;

    for (genvar row = 0; row < NCH; row++) begin : g_row
        assign mout[row] = mat_row(coefs[row*NCH], coefs[row*NCH+1], coefs[row*NCH+2],
                                   pin[0], pin[1], pin[2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_line  <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_line  <= s1_line;
            out_pix   <= bypass ? s1_pix : '{r: mout[0], g: mout[1], b: mout[2]};
        end
    end

    assert_bypass_pass_R4: assert property (@(posedge clk) disable iff (rst)
        bypass |=> out_pix == $past(s1_pix));
    assert_identity_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (!bypass && coefs == identity_mat()) |=> out_pix == $past(s1_pix));
endmodule

// File: rtl/rgb_ccm.sv
`timescale 1ns/1ps
module rgb_ccm
    import ccm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_line,
    input  logic [PIX_W-1:0]    in_r,
    input  logic [PIX_W-1:0]    in_g,
    input  logic [PIX_W-1:0]    in_b,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [COEF_W-1:0]   cfg_data,
    input  logic [1:0]          bank_cmd,
    input  logic [IDX_W-1:0]    bank_idx,
    output logic                out_valid,
    output logic                out_line,
    output logic [PIX_W-1:0]    out_r,
    output logic [PIX_W-1:0]    out_g,
    output logic [PIX_W-1:0]    out_b
);
    mat_t              coefs;
    wb_code_t [NCH-1:0] codes;
    logic              bypass;
    logic              s1_valid, s1_line;
    rgb_t              in_pix, s1_pix, out_pix;
    logic [1:0]        since_rst;

    assign in_pix = '{r: in_r, g: in_g, b: in_b};

    ccm_coef_bank u_bank (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .bank_cmd(bank_cmd), .bank_idx(bank_idx),
        .act(coefs), .wb_codes(codes), .bypass(bypass)
    );

    ccm_wb_stage u_wb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_line(in_line), .in_pix(in_pix),
        .codes(codes), .s1_valid(s1_valid), .s1_line(s1_line), .s1_pix(s1_pix)
    );

    ccm_matrix_stage u_mat (
        .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_line(s1_line), .s1_pix(s1_pix),
        .coefs(coefs), .bypass(bypass),
        .out_valid(out_valid), .out_line(out_line), .out_pix(out_pix)
    );

    assign out_r = out_pix.r;
    assign out_g = out_pix.g;
    assign out_b = out_pix.b;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_sideband_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2) && out_line == $past(in_line, 2)));
endmodule

// File: tb/sim_rgb_ccm.sv
`timescale 1ns/1ps
module sim_rgb_ccm;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid, in_line, cfg_we;
    logic [11:0] in_r, in_g, in_b;
    logic [3:0]  cfg_addr, bank_idx;
    logic [9:0]  cfg_data;
    logic [1:0]  bank_cmd;
    logic        out_valid, out_line;
    logic [11:0] out_r, out_g, out_b;

    always #2.5 clk = ~clk;

    rgb_ccm u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_line(in_line),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .bank_cmd(bank_cmd), .bank_idx(bank_idx),
        .out_valid(out_valid), .out_line(out_line),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    int wbm [64];
    int cm [9];
    int slot_m [4][9];
    int wbc [3];
    bit byp;

    localparam int STIM [8][3] = '{
        '{0, 0, 0}, '{4095, 4095, 4095}, '{100, 200, 300}, '{4095, 0, 0},
        '{0, 4095, 0}, '{0, 0, 4095}, '{2048, 1024, 512}, '{1, 2, 3}
    };

    function automatic int pre(input int p, input int i);
        int t5 [9];
        t5 = '{146, 33, -51, -24, 219, -67, -58, -83, 269};
        case (p)
            5: return t5[i];
            6: return (i == 0 || i == 4 || i == 8) ? 128 : 0;
            7: return (i == 0 || i == 4 || i == 8) ? 160 : -16;
            default: return (i == 0 || i == 4 || i == 8) ? 136 : -4;
        endcase
    endfunction

    function automatic int exp_wb(input int x, input int code);
        int v;
        v = (x * wbm[code] + 512) >> 10;
        return (v > 4095) ? 4095 : v;
    endfunction

    function automatic int exp_row(input int row, input int a, input int b, input int c);
        int acc;
        acc = cm[row*3] * a + cm[row*3+1] * b + cm[row*3+2] * c;
        acc = (acc + 64) >>> 7;
        if (acc < 0) return 0;
        if (acc > 4095) return 4095;
        return acc;
    endfunction

    function automatic bit bank_ok(input int cmd, input int idx);
        return (cmd == 1 && idx >= 1 && idx <= 4) || (cmd == 2 && idx >= 1 && idx <= 8);
    endfunction

    function automatic void model_cfg(input int addr, input int data);
        if (addr < 9) cm[addr] = (data & 512) ? (data & 1023) - 1024 : (data & 1023);
        else if (addr < 12) wbc[addr-9] = data & 63;
        else if (addr == 12) byp = bit'(data & 1);
    endfunction

    function automatic void model_bank(input int cmd, input int idx);
        if (cmd == 1 && idx >= 1 && idx <= 4)
            for (int i = 0; i < 9; i++) slot_m[idx-1][i] = cm[i];
        else if (cmd == 2 && idx >= 1 && idx <= 4)
            for (int i = 0; i < 9; i++) cm[i] = slot_m[idx-1][i];
        else if (cmd == 2 && idx >= 5 && idx <= 8)
            for (int i = 0; i < 9; i++) cm[i] = pre(idx, i);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_data = 10'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg(addr, data);
    endtask

    task automatic bank(input int cmd, input int idx);
        @(negedge clk);
        bank_cmd = 2'(cmd); bank_idx = 4'(idx);
        @(negedge clk);
        bank_cmd = 2'd0;
        model_bank(cmd, idx);
    endtask

    task automatic cfg_and_bank(input int addr, input int data, input int cmd, input int idx);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_data = 10'(data);
        bank_cmd = 2'(cmd); bank_idx = 4'(idx);
        @(negedge clk);
        cfg_we = 1'b0; bank_cmd = 2'd0;
        if (bank_ok(cmd, idx)) model_bank(cmd, idx);
        else model_cfg(addr, data);
    endtask

    task automatic send(input int r, input int g, input int b, input bit ln, input string req);
        int wr, wg, wb, er, eg, eb;
        wr = exp_wb(r, wbc[0]); wg = exp_wb(g, wbc[1]); wb = exp_wb(b, wbc[2]);
        if (byp) begin er = wr; eg = wg; eb = wb; end
        else begin er = exp_row(0, wr, wg, wb); eg = exp_row(1, wr, wg, wb); eb = exp_row(2, wr, wg, wb); end
        @(negedge clk);
        in_valid = 1'b1; in_line = ln; in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
        @(negedge clk);
        in_valid = 1'b0; in_line = 1'b0;
        check("R1", "valid after one edge", int'(out_valid), 0);
        @(negedge clk);
        check("R1", "valid after two edges", int'(out_valid), 1);
        check("R1", "line flag", int'(out_line), int'(ln));
        check(req, "red", int'(out_r), er);
        check(req, "green", int'(out_g), eg);
        check(req, "blue", int'(out_b), eb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wbm[0] = 1024;
        for (int k = 1; k < 64; k++) wbm[k] = (wbm[k-1] * 66990 + 32768) >>> 16;
        for (int i = 0; i < 9; i++) begin
            cm[i] = pre(6, i);
            for (int s = 0; s < 4; s++) slot_m[s][i] = pre(6, i);
        end
        wbc = '{0, 0, 0};
        byp = 1'b0;
        in_valid = 1'b1; in_line = 1'b1; in_r = 12'd5; in_g = 12'd6; in_b = 12'd7;
        cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0; bank_cmd = '0; bank_idx = '0;
        repeat (3) @(negedge clk);
        // R9: outputs held at zero during reset even with live input
        check("R9", "reset valid", int'(out_valid), 0);
        check("R9", "reset line", int'(out_line), 0);
        check("R9", "reset red", int'(out_r), 0);
        check("R9", "reset blue", int'(out_b), 0);
        in_valid = 1'b0; in_line = 1'b0;
        rst = 1'b0;

        // Table walk under four configurations
        for (int ph = 0; ph < 4; ph++) begin
            string tag;
            case (ph)
                0: tag = "R9";
                1: begin bank(2, 5); tag = "R3"; end
                2: begin cfg(9, 63); cfg(10, 32); cfg(11, 10); tag = "R2"; end
                default: begin cfg(12, 1); tag = "R4"; end
            endcase
            for (int i = 0; i < 8; i++) send(STIM[i][0], STIM[i][1], STIM[i][2], bit'(i % 2), tag);
        end
        cfg(12, 0); cfg(9, 0); cfg(10, 0); cfg(11, 0);

        // R6 and R7: store preset into slot 2, switch away, recall it
        bank(1, 2);
        bank(2, 6);
        send(100, 200, 300, 1'b1, "R7");
        bank(2, 2);
        send(1000, 2000, 500, 1'b0, "R6");
        // R7: out-of-range recall indices leave the matrix alone
        bank(2, 0); bank(2, 9); bank(2, 15);
        send(3000, 100, 700, 1'b1, "R7");
        // R7: preset 7 and 8
        bank(2, 7);
        send(1000, 500, 250, 1'b0, "R7");
        bank(2, 8);
        send(4000, 10, 2000, 1'b0, "R7");

        // R8: accepted recall drops the write; ignored recall lets it through
        cfg_and_bank(0, 300, 2, 6);
        send(100, 50, 25, 1'b0, "R8");
        cfg_and_bank(0, 300, 2, 0);
        send(100, 50, 25, 1'b0, "R8");

        // R3: coefficient extremes, negative sum clamps to zero
        cfg(0, 511); cfg(1, -512); cfg(2, 0);
        send(100, 50, 7, 1'b1, "R3");
        send(0, 100, 0, 1'b0, "R3");

        // R5: unused addresses change nothing
        cfg(13, 1023); cfg(14, 1023); cfg(15, 1023);
        send(100, 50, 7, 1'b1, "R5");
        cfg(12, 2);
        send(4095, 4095, 4095, 1'b0, "R5");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule